// File: doc/BRIEF.md
# Indirect Byte Register Access Bridge

The bridge lets a host reach a private register space through one 32-bit control word. That space has 8-bit addresses and 8-bit data. The host writes the word with a target address, a data byte and a direction bit. The bridge then carries out the internal access over a fixed number of cycles. While the access runs, a busy flag reads back as set.

Read data is returned in the top byte of the same word. Software starts a read, polls the word until busy drops, and then takes the byte.

A small register-file model sits behind the bridge, so the whole host-to-register path can be exercised. Only the lowest `NUM_REGS` addresses are implemented. Every other address takes no writes and reads as zero. The internal access latency is the parameter `LATENCY`, which must be at least 1.

Top module: `ibb_top`

## Requirements
- R1: Control word layout, as written by the host and read back:
  - [7:0] internal address.
  - [15:8] write byte.
  - [16] direction, where 1 means write and 0 means read.
  - [23] busy.
  - [31:24] read byte.
  - Bits [22:17] always read as zero.
  - Fields [16:0] read back the values of the last accepted request.
- R2: After reset the control word reads as all zeros, and every implemented register holds zero.
- R3: A host write accepted while idle sets busy from the next cycle. Busy stays set for exactly `LATENCY` cycles and then clears.
- R4: A write request stores its byte into the addressed implemented register when busy clears. A later read returns that byte.
- R5: A read request places the addressed register's byte in [31:24] in the same cycle that busy clears.
- R6: A host write that arrives while busy is set is ignored. It does not change the request fields, the busy timing or any register.
- R7: The read byte in [31:24] keeps its value through write requests until the next read completes.
- R8: Addresses at or above `NUM_REGS` are not implemented. Writing one changes no register, and reading one returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write strobe for the control word |
| host_wdata_i | input | 32 | Control word written by the host |
| host_rdata_o | output | 32 | Control word read back by the host |

## Verification
Take the clock edge that accepts a request as edge 0. Busy is sampled on the falling edge after edge 0 and on each of the next `LATENCY-1` falling edges, and must be set on all of them. It must be clear on the falling edge after edge `LATENCY`, and that same sample carries the read byte.

Every access in the bench steps through this fixed sequence, so each value is compared exactly in the cycle it is due. The bench sweeps all 256 addresses with writes and then with reads. The expected byte is computed from the address, and addresses at or above `NUM_REGS` are expected to read zero. Dedicated sequences check a write that collides with a busy access and the holding of the read byte.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BYTE_W = 8;

  // control word bit positions
  localparam int unsigned ADDR_LSB  = 0;
  localparam int unsigned WDATA_LSB = 8;
  localparam int unsigned DIR_BIT   = 16;
  localparam int unsigned BUSY_BIT  = 23;
  localparam int unsigned RDATA_LSB = 24;

  typedef struct packed {
    logic              wr;
    logic [BYTE_W-1:0] wdata;
    logic [ADDR_W-1:0] addr;
  } ibb_req_t;

  function automatic ibb_req_t unpack_word(input logic [WORD_W-1:0] w);
    ibb_req_t r;
    r.addr  = w[ADDR_LSB  +: ADDR_W];
    r.wdata = w[WDATA_LSB +: BYTE_W];
    r.wr    = w[DIR_BIT];
    return r;
  endfunction
endpackage

// File: rtl/ibb_regfile.sv
module ibb_regfile
  import ibb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;
  logic hit;

  assign hit = {1'b0, addr_i} < LIMIT;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && hit && (addr_i == ADDR_W'(g))) regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
  end

  AST_UNIMPL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> $stable(regs_q)); // R8
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q)); // R6
endmodule

// File: rtl/ibb_ctrl.sv
module ibb_ctrl
  import ibb_pkg::*;
#(
  parameter int unsigned LATENCY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic [BYTE_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output ibb_req_t          req_o,
  output logic              busy_o,
  output logic [BYTE_W-1:0] rd_byte_o
);
  localparam int unsigned CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  ibb_req_t          req_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rd_q;
  logic              start, done;

  assign start = host_we_i && !busy_q;
  assign done  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      req_q  <= unpack_word(host_wdata_i);
      busy_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // read byte captured only on read completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (done && !req_q.wr) rd_q <= rf_rdata_i;
  end

  assign rf_we_o   = done && req_q.wr;
  assign req_o     = req_q;
  assign busy_o    = busy_q;
  assign rd_byte_o = rd_q;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy_q); // R3
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q <= CNT_LOAD)); // R3
  AST_BUSY_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && host_we_i) |=> $stable(req_q)); // R6
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done && !req_q.wr) |=> $stable(rd_q)); // R7
  AST_WE_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !busy_o); // R4
endmodule

// File: rtl/ibb_top.sv
module ibb_top
  import ibb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned LATENCY  = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_we_i,
  input  logic [31:0] host_wdata_i,
  output logic [31:0] host_rdata_o
);
  ibb_req_t          req;
  logic              rf_we, busy;
  logic [BYTE_W-1:0] rf_rdata, rd_byte;

  ibb_ctrl #(.LATENCY(LATENCY)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_wdata_i (host_wdata_i),
    .rf_rdata_i   (rf_rdata),
    .rf_we_o      (rf_we),
    .req_o        (req),
    .busy_o       (busy),
    .rd_byte_o    (rd_byte)
  );

  ibb_regfile #(.NUM_REGS(NUM_REGS)) i_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .addr_i  (req.addr),
    .wdata_i (req.wdata),
    .rdata_o (rf_rdata)
  );

  always_comb begin
    host_rdata_o = '0;
    host_rdata_o[ADDR_LSB  +: ADDR_W] = req.addr;
    host_rdata_o[WDATA_LSB +: BYTE_W] = req.wdata;
    host_rdata_o[DIR_BIT]             = req.wr;
    host_rdata_o[BUSY_BIT]            = busy;
    host_rdata_o[RDATA_LSB +: BYTE_W] = rd_byte;
  end

  AST_READ_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !host_rdata_o[BUSY_BIT]); // R5
endmodule

// File: tb/test_ibb_top.sv
module test_ibb_top;
  localparam int NUM_REGS = 16;
  localparam int LATENCY  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ibb_top #(.NUM_REGS(NUM_REGS), .LATENCY(LATENCY)) i_ibb_top (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we),
    .host_wdata_i(wdata), .host_rdata_o(rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one access, check busy timing; returns word after completion
  task automatic access(input logic [7:0] addr, input logic [7:0] d, input bit wr,
                        input bit collide, output logic [31:0] word);
    @(negedge clk);
    we = 1'b1; wdata = {8'h00, 7'h00, wr, d, addr};
    @(posedge clk);
    @(negedge clk);
    if (collide) begin
      we = 1'b1; wdata = {8'hFF, 7'h7F, ~wr, ~d, addr ^ 8'h01};
    end else we = 1'b0;
    check(rdata[23] == 1'b1, "R3 busy after accept", 32'(rdata[23]), 1);
    check(rdata[16:0] == {wr, d, addr}, "R1 request fields", 32'(rdata[16:0]), 32'({wr, d, addr}));
    for (int i = 0; i < LATENCY - 1; i++) begin
      @(negedge clk);
      we = 1'b0;
      check(rdata[23] == 1'b1, "R3 busy held", 32'(rdata[23]), 1);
    end
    @(negedge clk);
    we = 1'b0;
    check(rdata[23] == 1'b0, "R3 busy cleared", 32'(rdata[23]), 0);
    check(rdata[22:17] == 6'd0, "R1 reserved zero", 32'(rdata[22:17]), 0);
    if (collide)
      check(rdata[16:0] == {wr, d, addr}, "R6 fields kept", 32'(rdata[16:0]), 32'({wr, d, addr}));
    word = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rdata == 32'd0, "R2 reset word", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata == 32'd0, "R2 word after release", rdata, 0);
    access(8'd0, 8'd0, 1'b0, 1'b0, w);
    check(w[31:24] == 8'd0, "R2 reg0 reset", 32'(w[31:24]), 0);
    access(8'(NUM_REGS - 1), 8'd0, 1'b0, 1'b0, w);
    check(w[31:24] == 8'd0, "R2 top reg reset", 32'(w[31:24]), 0);

    // R4 R8: write sweep over all addresses
    for (int a = 0; a < 256; a++) access(8'(a), pat(a), 1'b1, 1'b0, w);
    // R5 R8: read sweep
    for (int a = 0; a < 256; a++) begin
      logic [7:0] exp;
      exp = (a < NUM_REGS) ? pat(a) : 8'd0;
      access(8'(a), 8'hC3, 1'b0, 1'b0, w);
      check(w[31:24] == exp, (a < NUM_REGS) ? "R5 R4 read back" : "R8 unimplemented reads zero",
            32'(w[31:24]), 32'(exp));
    end

    // R6: colliding write during busy is ignored
    access(8'd5, 8'hAA, 1'b1, 1'b1, w);
    access(8'd4, 8'h00, 1'b0, 1'b0, w);
    check(w[31:24] == pat(4), "R6 neighbour untouched", 32'(w[31:24]), 32'(pat(4)));
    access(8'd5, 8'h00, 1'b0, 1'b0, w);
    check(w[31:24] == 8'hAA, "R6 first access done", 32'(w[31:24]), 32'hAA);
    access(8'd3, 8'h00, 1'b0, 1'b1, w);
    check(w[31:24] == pat(3), "R6 read not disturbed", 32'(w[31:24]), 32'(pat(3)));
    access(8'd2, 8'h00, 1'b0, 1'b0, w);
    check(w[31:24] == pat(2), "R6 no write from collision", 32'(w[31:24]), 32'(pat(2)));

    // R7: read byte holds over writes
    held = pat(2);
    access(8'd7, 8'h5A, 1'b1, 1'b0, w);
    check(w[31:24] == held, "R7 hold after write", 32'(w[31:24]), 32'(held));
    access(8'd200, 8'h77, 1'b1, 1'b0, w);
    check(w[31:24] == held, "R7 hold after unimpl write", 32'(w[31:24]), 32'(held));
    repeat (5) @(negedge clk);
    check(rdata[31:24] == held, "R7 hold while idle", 32'(rdata[31:24]), 32'(held));
    access(8'd7, 8'h00, 1'b0, 1'b0, w);
    check(w[31:24] == 8'h5A, "R4 overwrite", 32'(w[31:24]), 32'h5A);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule